// File: doc/BRIEF.md
# Accumulator Processor Core (24-bit)

This block is a compact multi-cycle processor built around one 24-bit accumulator. It fetches three-byte instructions from a byte-wide synchronous memory and executes a reduced instruction set: loads and stores of the accumulator, the index register and the linkage register, add and subtract, a signed compare that leaves a three-valued condition code, conditional and unconditional jumps, subroutine call and return, and byte I/O with numbered devices. Each instruction takes several clock cycles. The memory port moves one byte per cycle, and reads have a fixed latency of one cycle.

The memory port has no back-pressure. The core presents an address in one cycle and uses the read byte in the next cycle, and writes take effect at the clock edge where `mem_we` is high. The device port uses a ready/strobe handshake. A read or write instruction holds the core in a wait state for as long as `dev_ready` is low. The transfer completes in the first cycle in which `dev_ready` is high, and in that cycle the core raises exactly one of `dev_rstb` or `dev_wstb` for one cycle. A device stalls the core by holding `dev_ready` low. An undefined opcode stops the core. It then raises `halt` and stays halted until reset.

Top module: `acc24_core`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `mem_addr` is 0, `mem_we` is low and `halt` is low. Registers A, X, L and the program counter reset to 0.
- R2: An instruction is three bytes read at PC, PC+1 and PC+2 in consecutive cycles. Byte 0 is the opcode. Bit 7 of byte 1 is the index flag. Bits 6:0 of byte 1 and all of byte 2 form the 15-bit address field, most significant bits first. After a fetch, PC advances by 3.
- R3: The target address is the address field when the index flag is 0. When the flag is 1 it is the address field plus X[14:0], wrapped modulo 2^15.
- R4: LDA (00h), LDX (04h) and LDL (08h) read three bytes at target, target+1 and target+2. The first byte read is the most significant. The loaded word goes into A, X or L.
- R5: STA (0Ch), STX (10h) and STL (14h) write A, X or L as three bytes to target, target+1 and target+2, most significant byte first. `mem_we` is high for exactly those three consecutive cycles.
- R6: ADD (18h) and SUB (1Ch) replace A with A plus or minus the memory word, modulo 2^24.
- R7: COMP (28h) compares A with the memory word as signed 24-bit values. It sets the condition code to less (00), equal (01) or greater (10). JLT (38h), JEQ (30h) and JGT (34h) load PC with the target only when the code matches. J (3Ch) always jumps.
- R8: JSUB (48h) writes the address of the following instruction into L and jumps to the target. RSUB (4Ch) jumps to L[14:0].
- R9: TD (E0h) sets the condition code to equal (01) when `dev_ready` is high and to less (00) when it is low. It raises no device strobe.
- R10: RD (D8h) and WD (DCh) drive the low byte of the address field on `dev_code` and wait while `dev_ready` is low, with both strobes low. RD replaces A[7:0] with `dev_rdata` and keeps A[23:8]. WD presents A[7:0] on `dev_wdata`. Each raises its own strobe for one cycle, never both at once.
- R11: Any other opcode raises `halt`. `halt` then stays high with no memory write and no device strobe until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 15 | Byte address for the memory read or write |
| mem_wdata | output | 8 | Byte to be written |
| mem_we | output | 1 | Write enable for the byte at `mem_addr` |
| mem_rdata | input | 8 | Byte read from the previous cycle's address |
| dev_code | output | 8 | Number of the selected device |
| dev_ready | input | 1 | Device is ready to transfer |
| dev_rdata | input | 8 | Byte offered by the device |
| dev_rstb | output | 1 | One-cycle strobe: core takes `dev_rdata` |
| dev_wstb | output | 1 | One-cycle strobe: `dev_wdata` is valid |
| dev_wdata | output | 8 | Byte sent to the device |
| halt | output | 1 | Core stopped on an undefined opcode |

## Verification
Assertions check every cycle that a halted core stays halted and stays silent on both ports. They also check that device strobes appear only while `dev_ready` is high and never together, that a store burst steps through consecutive addresses and ends after three writes, and that fetching starts at address 0 after reset. The correctness of the arithmetic, the compare outcome driving branch selection, indexed address wrap, the return address taken by a call, and the byte merge on a device read can only be shown by running programs and inspecting the memory they leave behind.

// File: rtl/acc24_pkg.sv
package acc24_pkg;
  localparam int ADDR_W = 15;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 24;

  localparam logic [7:0] OPC_LDA  = 8'h00;
  localparam logic [7:0] OPC_LDX  = 8'h04;
  localparam logic [7:0] OPC_LDL  = 8'h08;
  localparam logic [7:0] OPC_STA  = 8'h0C;
  localparam logic [7:0] OPC_STX  = 8'h10;
  localparam logic [7:0] OPC_STL  = 8'h14;
  localparam logic [7:0] OPC_ADD  = 8'h18;
  localparam logic [7:0] OPC_SUB  = 8'h1C;
  localparam logic [7:0] OPC_COMP = 8'h28;
  localparam logic [7:0] OPC_JEQ  = 8'h30;
  localparam logic [7:0] OPC_JGT  = 8'h34;
  localparam logic [7:0] OPC_JLT  = 8'h38;
  localparam logic [7:0] OPC_J    = 8'h3C;
  localparam logic [7:0] OPC_JSUB = 8'h48;
  localparam logic [7:0] OPC_RSUB = 8'h4C;
  localparam logic [7:0] OPC_RD   = 8'hD8;
  localparam logic [7:0] OPC_WD   = 8'hDC;
  localparam logic [7:0] OPC_TD   = 8'hE0;

  typedef enum logic [1:0] {
    CC_LT = 2'b00,
    CC_EQ = 2'b01,
    CC_GT = 2'b10
  } cc_e;

  typedef enum logic [1:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB
  } alu_op_e;

  typedef enum logic [3:0] {
    S_F0, S_F1, S_F2, S_F3, S_EX,
    S_R0, S_R1, S_R2, S_R3,
    S_W0, S_W1, S_W2,
    S_IO, S_HALT
  } state_e;
endpackage

// File: rtl/acc24_agu.sv
module acc24_agu #(
  parameter int AW = 15
) (
  input  logic [AW-1:0] field,
  input  logic          idx_en,
  input  logic [AW-1:0] xval,
  input  logic [1:0]    byte_ofs,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] idx_term;
  logic [AW-1:0] ofs_term;

  assign idx_term = idx_en ? xval : '0;
  assign ofs_term = {{(AW-2){1'b0}}, byte_ofs};
  assign addr     = field + idx_term + ofs_term;
endmodule

// File: rtl/acc24_alu.sv
module acc24_alu
  import acc24_pkg::*;
#(
  parameter int W = 24
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  input  alu_op_e      op,
  output logic [W-1:0] res,
  output cc_e          cmp
);
  always_comb begin
    unique case (op)
      ALU_ADD: res = acc + opnd;
      ALU_SUB: res = acc - opnd;
      default: res = opnd;
    endcase
  end

  always_comb begin
    if (acc == opnd)                    cmp = CC_EQ;
    else if ($signed(acc) < $signed(opnd)) cmp = CC_LT;
    else                                cmp = CC_GT;
  end
endmodule

// File: rtl/acc24_core.sv
module acc24_core
  import acc24_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [BYTE_W-1:0] dev_code,
  input  logic              dev_ready,
  input  logic [BYTE_W-1:0] dev_rdata,
  output logic              dev_rstb,
  output logic              dev_wstb,
  output logic [BYTE_W-1:0] dev_wdata,
  output logic              halt
);
  localparam int HI_W = WORD_W - BYTE_W;

  state_e            state;
  logic [ADDR_W-1:0] pc;
  logic [WORD_W-1:0] acc_q, idx_q, lnk_q;
  cc_e               cc;
  logic [7:0]        op_q, b1_q, b2_q;
  logic [HI_W-1:0]   hi_q;

  logic [1:0]        ofs;
  logic [ADDR_W-1:0] fetch_addr, tgt_addr;
  logic [ADDR_W-1:0] field;
  logic [WORD_W-1:0] opnd, alu_res, st_src;
  alu_op_e           alu_op;
  cc_e               cmp_cc;
  logic              data_phase;

  assign field = {b1_q[6:0], b2_q};
  assign opnd  = {hi_q, mem_rdata};

  always_comb begin
    unique case (state)
      S_F1, S_R1, S_W1: ofs = 2'd1;
      S_F2, S_R2, S_W2: ofs = 2'd2;
      default:          ofs = 2'd0;
    endcase
  end

  acc24_agu #(.AW(ADDR_W)) u_fetch_agu (
    .field(pc), .idx_en(1'b0), .xval('0), .byte_ofs(ofs), .addr(fetch_addr)
  );

  acc24_agu #(.AW(ADDR_W)) u_data_agu (
    .field(field), .idx_en(b1_q[7]), .xval(idx_q[ADDR_W-1:0]),
    .byte_ofs(ofs), .addr(tgt_addr)
  );

  always_comb begin
    if (op_q == OPC_ADD)      alu_op = ALU_ADD;
    else if (op_q == OPC_SUB) alu_op = ALU_SUB;
    else                      alu_op = ALU_PASS;
  end

  acc24_alu #(.W(WORD_W)) u_alu (
    .acc(acc_q), .opnd(opnd), .op(alu_op), .res(alu_res), .cmp(cmp_cc)
  );

  always_comb begin
    if (op_q == OPC_STX)      st_src = idx_q;
    else if (op_q == OPC_STL) st_src = lnk_q;
    else                      st_src = acc_q;
  end

  assign data_phase = (state == S_R0) || (state == S_R1) || (state == S_R2) ||
                      (state == S_W0) || (state == S_W1) || (state == S_W2);
  assign mem_addr   = data_phase ? tgt_addr : fetch_addr;
  assign mem_we     = (state == S_W0) || (state == S_W1) || (state == S_W2);

  always_comb begin
    unique case (state)
      S_W0:    mem_wdata = st_src[23:16];
      S_W1:    mem_wdata = st_src[15:8];
      default: mem_wdata = st_src[7:0];
    endcase
  end

  assign dev_code  = b2_q;
  assign dev_wdata = acc_q[7:0];
  assign dev_rstb  = (state == S_IO) && (op_q == OPC_RD) && dev_ready;
  assign dev_wstb  = (state == S_IO) && (op_q == OPC_WD) && dev_ready;
  assign halt      = (state == S_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_F0;
      pc    <= '0;
      acc_q <= '0;
      idx_q <= '0;
      lnk_q <= '0;
      cc    <= CC_EQ;
      op_q  <= '0;
      b1_q  <= '0;
      b2_q  <= '0;
      hi_q  <= '0;
    end else begin
      unique case (state)
        S_F0: state <= S_F1;
        S_F1: begin op_q <= mem_rdata; state <= S_F2; end
        S_F2: begin b1_q <= mem_rdata; state <= S_F3; end
        S_F3: begin
          b2_q  <= mem_rdata;
          pc    <= pc + ADDR_W'(3);
          state <= S_EX;
        end
        S_EX: begin
          state <= S_F0;
          unique case (op_q)
            OPC_LDA, OPC_LDX, OPC_LDL,
            OPC_ADD, OPC_SUB, OPC_COMP: state <= S_R0;
            OPC_STA, OPC_STX, OPC_STL:  state <= S_W0;
            OPC_J:    pc <= tgt_addr;
            OPC_JEQ:  if (cc == CC_EQ) pc <= tgt_addr;
            OPC_JGT:  if (cc == CC_GT) pc <= tgt_addr;
            OPC_JLT:  if (cc == CC_LT) pc <= tgt_addr;
            OPC_JSUB: begin
              lnk_q <= {{(WORD_W-ADDR_W){1'b0}}, pc};
              pc    <= tgt_addr;
            end
            OPC_RSUB: pc <= lnk_q[ADDR_W-1:0];
            OPC_TD:   cc <= dev_ready ? CC_EQ : CC_LT;
            OPC_RD, OPC_WD: state <= S_IO;
            default:  state <= S_HALT;
          endcase
        end
        S_R0: state <= S_R1;
        S_R1: begin hi_q[HI_W-1:8] <= mem_rdata; state <= S_R2; end
        S_R2: begin hi_q[7:0] <= mem_rdata; state <= S_R3; end
        S_R3: begin
          state <= S_F0;
          unique case (op_q)
            OPC_LDX:  idx_q <= opnd;
            OPC_LDL:  lnk_q <= opnd;
            OPC_COMP: cc    <= cmp_cc;
            default:  acc_q <= alu_res;
          endcase
        end
        S_W0: state <= S_W1;
        S_W1: state <= S_W2;
        S_W2: state <= S_F0;
        S_IO: begin
          if (dev_ready) begin
            if (op_q == OPC_RD) acc_q[7:0] <= dev_rdata;
            state <= S_F0;
          end
        end
        default: state <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/acc24_core_chk.sv
module acc24_core_chk
  import acc24_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              dev_ready,
  input logic              dev_rstb,
  input logic              dev_wstb,
  input logic              halt
);
  p_fetch_from_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mem_addr == '0 && !mem_we && !halt));

  p_store_steps_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |=> (mem_we && mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  p_store_three_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we) && $past(mem_we, 2)) |=> !mem_we);

  p_strobe_ready_r10: assert property (@(posedge clk) disable iff (rst)
    (dev_rstb || dev_wstb) |-> dev_ready);

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dev_rstb, dev_wstb}));

  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);

  p_halt_silent_r11: assert property (@(posedge clk) disable iff (rst)
    halt |-> (!mem_we && !dev_rstb && !dev_wstb));
endmodule

bind acc24_core acc24_core_chk u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
  .dev_ready(dev_ready), .dev_rstb(dev_rstb), .dev_wstb(dev_wstb), .halt(halt)
);

// File: tb/acc24_core_tb.sv
module acc24_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we;
  logic [7:0]  dev_code, dev_rdata, dev_wdata;
  logic        dev_ready, dev_rstb, dev_wstb, halt;

  int vectors = 0;
  int miscompares = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [7:0] rd_code, wr_code, wr_byte;
  logic [7:0] mem [0:4095];

  always #10 clk = ~clk;

  acc24_core u_dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .dev_code(dev_code),
    .dev_ready(dev_ready), .dev_rdata(dev_rdata), .dev_rstb(dev_rstb),
    .dev_wstb(dev_wstb), .dev_wdata(dev_wdata), .halt(halt)
  );

  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr[11:0]];
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    if (dev_rstb) begin rd_cnt <= rd_cnt + 1; rd_code <= dev_code; end
    if (dev_wstb) begin wr_cnt <= wr_cnt + 1; wr_code <= dev_code; wr_byte <= dev_wdata; end
  end

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 8'hEE;
  endtask

  task automatic put_ins(input int adr, input logic [7:0] op, input logic xb, input logic [14:0] f);
    mem[adr] = op; mem[adr+1] = {xb, f[14:8]}; mem[adr+2] = f[7:0];
  endtask

  task automatic put_word(input int adr, input logic [23:0] w);
    mem[adr] = w[23:16]; mem[adr+1] = w[15:8]; mem[adr+2] = w[7:0];
  endtask

  function automatic logic [23:0] get_word(input int adr);
    return {mem[adr], mem[adr+1], mem[adr+2]};
  endfunction

  function automatic logic [23:0] exp_arith(input logic [23:0] a, b, c);
    return a + b - c;
  endfunction

  function automatic logic [23:0] exp_cmp_path(input logic [23:0] a, b);
    if ($signed(a) < $signed(b)) return 24'd1;
    if (a == b) return 24'd2;
    return 24'd3;
  endfunction

  task automatic reset_cpu();
    @(negedge clk); rst = 1'b1;
    rd_cnt = 0; wr_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic run_to_halt(input string req);
    int n = 0;
    while (!halt && n < 3000) begin @(negedge clk); n++; end
    if (!halt) chk({req, " watchdog"}, 24'd0, 24'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [23:0] a, b, c, xv, dv;
    logic [14:0] fld, tgt;
    void'($urandom(32'd4242));
    dev_ready = 1'b0;
    dev_rdata = 8'h00;
    clear_mem();

    // R1 / R2: reset state and first fetch sequence
    put_ins(0, 8'hFF, 1'b0, 15'h0);
    reset_cpu();
    chk("R1 addr", {9'd0, mem_addr}, 24'd0);
    chk("R1 we/halt", {22'd0, mem_we, halt}, 24'd0);
    @(negedge clk); chk("R2 fetch byte1", {9'd0, mem_addr}, 24'd1);
    @(negedge clk); chk("R2 fetch byte2", {9'd0, mem_addr}, 24'd2);
    run_to_halt("R11");

    // R4 R5 R6: random add/subtract chains
    for (int k = 0; k < 20; k++) begin
      a = 24'($urandom); b = 24'($urandom); c = 24'($urandom);
      if (k == 0) begin a = 24'hFFFFFF; b = 24'h000001; c = 24'h000000; end
      if (k == 1) begin a = 24'h000000; b = 24'h000000; c = 24'h000001; end
      clear_mem();
      put_ins(0, 8'h00, 1'b0, 15'h400);
      put_ins(3, 8'h18, 1'b0, 15'h403);
      put_ins(6, 8'h1C, 1'b0, 15'h406);
      put_ins(9, 8'h0C, 1'b0, 15'h600);
      put_ins(12, 8'hFF, 1'b0, 15'h0);
      put_word(32'h400, a); put_word(32'h403, b); put_word(32'h406, c);
      reset_cpu();
      run_to_halt("R6");
      chk("R6 add/sub result", get_word(32'h600), exp_arith(a, b, c));
      if (k == 2) chk("R5 msb first", {16'd0, mem[32'h600]}, {16'd0, exp_arith(a, b, c)[23:16]});
    end

    // R7: compare and conditional branches
    for (int k = 0; k < 20; k++) begin
      a = 24'($urandom); b = 24'($urandom);
      if (k % 3 == 0) b = a;
      if (k == 1) begin a = 24'h800000; b = 24'h7FFFFF; end
      if (k == 2) begin a = 24'h000001; b = 24'hFFFFFF; end
      clear_mem();
      put_ins(0, 8'h00, 1'b0, 15'h400);
      put_ins(3, 8'h28, 1'b0, 15'h403);
      put_ins(6, 8'h38, 1'b0, 15'h020);
      put_ins(9, 8'h30, 1'b0, 15'h030);
      put_ins(12, 8'h34, 1'b0, 15'h040);
      put_ins(15, 8'hFF, 1'b0, 15'h0);
      put_ins(32'h20, 8'h00, 1'b0, 15'h410); put_ins(32'h23, 8'h3C, 1'b0, 15'h050);
      put_ins(32'h30, 8'h00, 1'b0, 15'h413); put_ins(32'h33, 8'h3C, 1'b0, 15'h050);
      put_ins(32'h40, 8'h00, 1'b0, 15'h416); put_ins(32'h43, 8'h3C, 1'b0, 15'h050);
      put_ins(32'h50, 8'h0C, 1'b0, 15'h600); put_ins(32'h53, 8'hFF, 1'b0, 15'h0);
      put_word(32'h400, a); put_word(32'h403, b);
      put_word(32'h410, 24'd1); put_word(32'h413, 24'd2); put_word(32'h416, 24'd3);
      reset_cpu();
      run_to_halt("R7");
      chk("R7 branch path", get_word(32'h600), exp_cmp_path(a, b));
    end

    // R3 R4 R5: indexed load, store of X and L
    for (int k = 0; k < 10; k++) begin
      xv = {9'd0, 15'($urandom_range(0, 255))};
      fld = 15'h440 + 15'($urandom_range(0, 255));
      if (k == 0) begin xv = 24'h000450; fld = 15'h7FF0; end
      if (k == 1) begin xv = 24'hABC000; fld = 15'h480; end
      tgt = fld + xv[14:0];
      dv = 24'($urandom);
      c = 24'($urandom);
      clear_mem();
      put_ins(0, 8'h04, 1'b0, 15'h400);
      put_ins(3, 8'h00, 1'b1, fld);
      put_ins(6, 8'h0C, 1'b0, 15'h600);
      put_ins(9, 8'h10, 1'b0, 15'h603);
      put_ins(12, 8'h08, 1'b0, 15'h406);
      put_ins(15, 8'h14, 1'b0, 15'h606);
      put_ins(18, 8'hFF, 1'b0, 15'h0);
      put_word(32'h400, xv); put_word(32'h406, c);
      put_word(int'(tgt[11:0]), dv);
      reset_cpu();
      run_to_halt("R3");
      chk("R3 indexed target", get_word(32'h600), dv);
      chk("R5 STX word", get_word(32'h603), xv);
      chk("R4 LDL/STL word", get_word(32'h606), c);
    end

    // R8: call and return
    dv = 24'h5A1C33;
    clear_mem();
    put_ins(0, 8'h48, 1'b0, 15'h200);
    put_ins(3, 8'h0C, 1'b0, 15'h600);
    put_ins(6, 8'h14, 1'b0, 15'h603);
    put_ins(9, 8'hFF, 1'b0, 15'h0);
    put_ins(32'h200, 8'h00, 1'b0, 15'h400);
    put_ins(32'h203, 8'h4C, 1'b0, 15'h0);
    put_word(32'h400, dv);
    reset_cpu();
    run_to_halt("R8");
    chk("R8 subroutine ran", get_word(32'h600), dv);
    chk("R8 return address", get_word(32'h603), 24'd3);

    // R9: device test, both ready states
    for (int k = 0; k < 2; k++) begin
      clear_mem();
      put_ins(0, 8'hE0, 1'b0, 15'h005);
      put_ins(3, 8'h30, 1'b0, 15'h020);
      put_ins(6, 8'h00, 1'b0, 15'h410);
      put_ins(9, 8'h0C, 1'b0, 15'h600);
      put_ins(12, 8'hFF, 1'b0, 15'h0);
      put_ins(32'h20, 8'h00, 1'b0, 15'h413);
      put_ins(32'h23, 8'h3C, 1'b0, 15'h009);
      put_word(32'h410, 24'd1); put_word(32'h413, 24'd2);
      dev_ready = (k == 1);
      reset_cpu();
      run_to_halt("R9");
      chk("R9 ready flag", get_word(32'h600), (k == 1) ? 24'd2 : 24'd1);
      chk("R9 no strobes", 24'(rd_cnt + wr_cnt), 24'd0);
    end

    // R10: read and write wait on ready
    dev_ready = 1'b0;
    dev_rdata = 8'hA5;
    clear_mem();
    put_ins(0, 8'h00, 1'b0, 15'h400);
    put_ins(3, 8'hD8, 1'b0, 15'h007);
    put_ins(6, 8'h0C, 1'b0, 15'h600);
    put_ins(9, 8'hDC, 1'b0, 15'h009);
    put_ins(12, 8'hFF, 1'b0, 15'h0);
    put_word(32'h400, 24'h123456);
    reset_cpu();
    repeat (40) @(negedge clk);
    chk("R10 wait no strobe", 24'(rd_cnt + wr_cnt), 24'd0);
    chk("R10 wait no halt", {23'd0, halt}, 24'd0);
    dev_ready = 1'b1;
    run_to_halt("R10");
    chk("R10 read merge", get_word(32'h600), 24'h1234A5);
    chk("R10 read strobes", 24'(rd_cnt), 24'd1);
    chk("R10 write strobes", 24'(wr_cnt), 24'd1);
    chk("R10 read code", {16'd0, rd_code}, 24'h07);
    chk("R10 write code", {16'd0, wr_code}, 24'h09);
    chk("R10 write byte", {16'd0, wr_byte}, 24'hA5);

    // R11: undefined opcode stops the core
    clear_mem();
    put_ins(0, 8'h00, 1'b0, 15'h400);
    put_ins(3, 8'h0C, 1'b0, 15'h600);
    put_ins(6, 8'h44, 1'b0, 15'h0);
    put_ins(9, 8'h0C, 1'b0, 15'h603);
    put_word(32'h400, 24'h0F0F0F);
    reset_cpu();
    run_to_halt("R11");
    repeat (20) @(negedge clk);
    chk("R11 halt held", {23'd0, halt}, 24'd1);
    chk("R11 no write after", get_word(32'h603), 24'hEEEEEE);
    chk("R11 prior store", get_word(32'h600), 24'h0F0F0F);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule